// File: doc/BRIEF.md
# Wavefront Fetch Eligibility Arbiter

This block watches a fixed set of wavefront slots and picks, at most once per cycle, the slot that may start an instruction fetch. Each slot reports four live inputs: whether the wavefront is running, how many entries its instruction buffer holds, whether that buffer holds a branch, and whether a fetch for it is still in flight. A slot that meets all four conditions and is not already waiting is placed at the back of an ordered ready queue. The head of that queue is granted. Address formation, the memory request and decode happen outside this block.

The grant is presented as a valid flag, the slot index and a one-hot pulse. The surrounding logic uses the pulse to set that slot's in-flight flag. Each slot carries a private waiting flag. This flag keeps the slot from entering the queue a second time, so a queue as deep as the slot count can never overflow. Once a slot is in the queue it is granted in its turn, even if its inputs change while it waits. Blocking eligibility when the buffer holds a branch stops fetches from running ahead of unresolved control flow.

A two-state controller tracks the queue. `ARB_IDLE` means the queue is empty and no grant is shown. `ARB_GRANT` means the head of the queue is granted. The transitions are: IDLE to GRANT when at least one slot is appended, GRANT to IDLE when the last entry is granted and nothing is appended, and any state to IDLE on reset. Otherwise the state holds.

Top module: `wf_fetch_arbiter`

## Requirements
- R1: A slot whose running input is low is never appended to the ready queue.
- R2: A slot is appended only if its buffer occupancy is at most OCC_LIMIT (default 4). An occupancy of 4 qualifies; an occupancy of 5 does not.
- R3: A slot whose has-branch input is high is never appended.
- R4: A slot whose pending input is high is never appended, so a slot whose fetch is in flight is not granted again.
- R5: A slot that meets R1 to R4 and is not waiting is appended at the next clock edge. Slots appended at the same edge enter in ascending index order. A waiting slot is never appended again.
- R6: grant_valid is high exactly when the ready queue is non-empty. grant_slot is then the oldest entry, and one entry leaves the queue per cycle.
- R7: grant_pend_set is one-hot at bit grant_slot while grant_valid is high, and all zero otherwise.
- R8: A granted slot leaves the queue at that edge. From the next cycle its inputs are evaluated again.
- R9: Changes to a waiting slot's four inputs are ignored. The slot is still granted when it reaches the head.
- R10: A synchronous reset (rst high at a clock edge) empties the queue and clears all waiting flags. grant_valid is low in the cycle after that edge.
- R11: A slot that becomes eligible in cycle t while the queue is empty is granted in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slot_running | input | NUM_SLOTS | Per-slot running status |
| slot_occ | input | NUM_SLOTS*OCC_W | Per-slot buffer occupancy, slot i at bits [i*OCC_W +: OCC_W] |
| slot_has_branch | input | NUM_SLOTS | Per-slot flag: buffer holds a branch |
| slot_pending | input | NUM_SLOTS | Per-slot flag: fetch in flight |
| grant_valid | output | 1 | A slot is granted this cycle |
| grant_slot | output | IDX_W | Index of the granted slot |
| grant_pend_set | output | NUM_SLOTS | One-hot pulse to set the granted slot's pending flag |

## Verification
The grant outputs come straight from registered queue state. Slot inputs seen before an edge change the queue at that edge, and their effect appears one cycle later (R11). A grant shown in cycle t drops the entry at the edge that ends cycle t. The bench lets the pending flag rise one cycle after the grant, which is how an external register would behave. The bench drives inputs just after each rising edge and compares all three outputs with a behavioural queue model at the falling edge. It then advances the model with the inputs that the next rising edge will capture, so that expected and actual values always refer to the same edge.

// File: rtl/wf_fetch_pkg.sv
package wf_fetch_pkg;

    // Controller states: queue empty, or head of queue granted
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_GRANT = 1'b1
    } arb_state_e;

endpackage

// File: rtl/wf_elig_eval.sv
module wf_elig_eval #(
    parameter int NUM_SLOTS = 8,
    parameter int OCC_W     = 4,
    parameter int OCC_LIMIT = 4
) (
    input  logic [NUM_SLOTS-1:0]       running,
    input  logic [NUM_SLOTS*OCC_W-1:0] occ,
    input  logic [NUM_SLOTS-1:0]       has_branch,
    input  logic [NUM_SLOTS-1:0]       pending,
    input  logic [NUM_SLOTS-1:0]       waiting,
    output logic [NUM_SLOTS-1:0]       enqueue
);

    localparam logic [OCC_W:0] LIMIT_V = OCC_LIMIT[OCC_W:0];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [OCC_W-1:0] occ_s;
        logic             room_ok;
        assign occ_s   = occ[g*OCC_W +: OCC_W];
        assign room_ok = ({1'b0, occ_s} <= LIMIT_V);
        // all four conditions, and not already waiting
        assign enqueue[g] = running[g] & room_ok & ~has_branch[g]
                          & ~pending[g] & ~waiting[g];
    end

endmodule

// File: rtl/wf_ready_fifo.sv
module wf_ready_fifo #(
    parameter  int DEPTH = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DEPTH-1:0] push_mask,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [CNT_W-1:0] count
);

    logic [IDX_W-1:0] mem_q [DEPTH];
    logic [IDX_W-1:0] head_q;
    logic [IDX_W-1:0] tail_q;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] offs [DEPTH];
    logic [CNT_W-1:0] push_cnt;

    function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] base,
                                                  input logic [CNT_W-1:0] step);
        logic [CNT_W:0] s;
        s = (CNT_W+1)'(base) + (CNT_W+1)'(step);
        if (s >= (CNT_W+1)'(DEPTH)) s = s - (CNT_W+1)'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    // prefix count gives each pushed index its slot behind the tail
    always_comb begin
        push_cnt = '0;
        for (int i = 0; i < DEPTH; i++) begin
            offs[i]  = push_cnt;
            push_cnt = push_cnt + CNT_W'(push_mask[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (push_mask[i]) mem_q[wrap_add(tail_q, offs[i])] <= IDX_W'(i);
            end
            tail_q  <= wrap_add(tail_q, push_cnt);
            head_q  <= pop ? wrap_add(head_q, CNT_W'(1)) : head_q;
            count_q <= count_q + push_cnt - CNT_W'(pop);
        end
    end

    assign head  = mem_q[head_q];
    assign count = count_q;

    // R6: the queue never exceeds its depth, including the next fill
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (32'(count_q) + 32'(push_cnt) - 32'(pop)) <= DEPTH);

    // R6: an entry leaves only when one exists
    a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count_q != '0));

endmodule

// File: rtl/wf_fetch_arbiter.sv
module wf_fetch_arbiter
    import wf_fetch_pkg::*;
#(
    parameter  int NUM_SLOTS = 8,
    parameter  int OCC_W     = 4,
    parameter  int OCC_LIMIT = 4,
    localparam int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SLOTS-1:0]       slot_running,
    input  logic [NUM_SLOTS*OCC_W-1:0] slot_occ,
    input  logic [NUM_SLOTS-1:0]       slot_has_branch,
    input  logic [NUM_SLOTS-1:0]       slot_pending,
    output logic                       grant_valid,
    output logic [IDX_W-1:0]           grant_slot,
    output logic [NUM_SLOTS-1:0]       grant_pend_set
);

    arb_state_e           state_q;
    arb_state_e           state_d;
    logic [NUM_SLOTS-1:0] waiting_q;
    logic [NUM_SLOTS-1:0] enq;
    logic [IDX_W-1:0]     head;
    logic [CNT_W-1:0]     count;

    wf_elig_eval #(
        .NUM_SLOTS (NUM_SLOTS),
        .OCC_W     (OCC_W),
        .OCC_LIMIT (OCC_LIMIT)
    ) u_elig (
        .running    (slot_running),
        .occ        (slot_occ),
        .has_branch (slot_has_branch),
        .pending    (slot_pending),
        .waiting    (waiting_q),
        .enqueue    (enq)
    );

    wf_ready_fifo #(
        .DEPTH (NUM_SLOTS)
    ) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push_mask (enq),
        .pop       (grant_valid),
        .head      (head),
        .count     (count)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (|enq) state_d = ARB_GRANT;
            ARB_GRANT: if ((count == CNT_W'(1)) && !(|enq)) state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    // state register and waiting flags
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            waiting_q <= '0;
        end else begin
            state_q   <= state_d;
            waiting_q <= (waiting_q | enq) & ~grant_pend_set;
        end
    end

    // outputs
    always_comb begin
        grant_valid    = (state_q == ARB_GRANT);
        grant_slot     = head;
        grant_pend_set = '0;
        if (grant_valid) grant_pend_set[head] = 1'b1;
    end

    // R5: queue entries and waiting flags stay in step, so no slot is queued twice
    a_r5_count_tracks_flags: assert property (@(posedge clk) disable iff (rst)
        32'(count) == $countones(waiting_q));

    // R6: controller state agrees with queue occupancy
    a_r6_state_matches_fill: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_GRANT) == (count != '0));

    // R7: pulse is one-hot and present only with a grant
    a_r7_pulse_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_pend_set) && (grant_valid == (|grant_pend_set)));

    // R8: a granted slot was waiting, and its flag is clear afterwards
    a_r8_granted_was_waiting: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> waiting_q[grant_slot]);

    a_r8_flag_cleared: assert property (@(posedge clk) disable iff (rst)
        grant_valid |=> !waiting_q[$past(grant_slot)]);

    // R10: no grant right after a reset edge
    a_r10_reset_empty: assert property (@(posedge clk)
        rst |=> !grant_valid);

endmodule

// File: tb/tb_wf_fetch_arbiter.sv
module tb_wf_fetch_arbiter;

    localparam int N     = 8;
    localparam int OW    = 4;
    localparam int LIM   = 4;
    localparam int IW    = $clog2(N);
    localparam int HOLD  = 9;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    run_b = '0;
    logic [N-1:0]    br_b  = '0;
    logic [N-1:0]    pend_b = '0;
    logic [OW-1:0]   occ_b [N];
    logic [N*OW-1:0] occ_flat;
    logic            grant_valid;
    logic [IW-1:0]   grant_slot;
    logic [N-1:0]    grant_pend_set;

    int checks = 0;
    int fails  = 0;

    int  mq[$];
    bit  mwait [N];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) occ_flat[i*OW +: OW] = occ_b[i];
    end

    wf_fetch_arbiter #(.NUM_SLOTS(N), .OCC_W(OW), .OCC_LIMIT(LIM)) dut (
        .clk             (clk),
        .rst             (rst),
        .slot_running    (run_b),
        .slot_occ        (occ_flat),
        .slot_has_branch (br_b),
        .slot_pending    (pend_b),
        .grant_valid     (grant_valid),
        .grant_slot      (grant_slot),
        .grant_pend_set  (grant_pend_set)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    function automatic string mode_tag(int m);
        case (m)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R9";
            default: return "R4";
        endcase
    endfunction

    // compare outputs with the model queue (R6, R7)
    task automatic compare(int m);
        logic [N-1:0] e;
        bit           ev;
        ev = (mq.size() != 0);
        e  = '0;
        if (ev) e[mq[0]] = 1'b1;
        check({"R6 valid/", mode_tag(m)}, grant_valid, ev);
        if (ev) check({"R6 oldest/", mode_tag(m)}, grant_slot, mq[0]);
        check({"R7 pulse/", mode_tag(m)}, grant_pend_set, e);
    endtask

    // advance the model with the inputs the next edge captures (R5, R8, R10)
    task automatic model_edge(output int g);
        int had;
        g = -1;
        if (rst) begin
            mq.delete();
            for (int i = 0; i < N; i++) mwait[i] = 0;
            return;
        end
        had = mq.size();
        for (int i = 0; i < N; i++) begin
            if (!mwait[i] && run_b[i] && (int'(occ_b[i]) <= LIM) && !br_b[i] && !pend_b[i]) begin
                mq.push_back(i);
                mwait[i] = 1;
            end
        end
        if (had != 0) begin
            g = mq.pop_front();
            mwait[g] = 0;
        end
    endtask

    task automatic randomize_inputs(int m, int g);
        for (int i = 0; i < N; i++) begin
            if (pend_b[i] && i != g && ($urandom % 3 == 0)) pend_b[i] = 1'b0;
            case (m)
                0: begin run_b[i] = $urandom % 2; occ_b[i] = OW'($urandom_range(0, 4)); br_b[i] = 0; end
                1: begin run_b[i] = 1; occ_b[i] = OW'($urandom_range(3, 6)); br_b[i] = 0; end
                2: begin run_b[i] = 1; occ_b[i] = OW'($urandom_range(0, 4)); br_b[i] = $urandom % 2; end
                default: begin
                    run_b[i] = ($urandom % 4) != 0;
                    occ_b[i] = OW'($urandom_range(0, 6));
                    br_b[i]  = ($urandom % 4) == 0;
                end
            endcase
        end
    endtask

    task automatic run_cycle(int m);
        int g;
        @(negedge clk);
        compare(m);
        model_edge(g);
        @(posedge clk);
        #1;
        if (g >= 0) pend_b[g] = 1'b1;
        if (rst) pend_b = '0;
        if (m != HOLD) randomize_inputs(m, g);
    endtask

    initial begin
        for (int i = 0; i < N; i++) occ_b[i] = '0;
        run_b = '1;
        // R10: reset held with every slot eligible
        @(posedge clk); #1;
        repeat (3) begin
            @(negedge clk);
            check("R10 no grant in reset", grant_valid, 0);
            mq.delete();
            for (int i = 0; i < N; i++) mwait[i] = 0;
            @(posedge clk); #1;
        end
        run_b = '0;
        rst   = 1'b0;
        repeat (2) run_cycle(HOLD);

        // R11: single slot becomes eligible, granted the next cycle
        run_b[3] = 1'b1;
        @(negedge clk);
        check("R11 not yet granted", grant_valid, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check("R11 valid one cycle later", grant_valid, 1);
        check("R11 slot", grant_slot, 3);
        @(posedge clk); #1;
        pend_b[3] = 1'b1;
        // R4: pending blocks a re-fetch of slot 3
        @(negedge clk);
        check("R4 pending blocks", grant_valid, 0);
        @(posedge clk); #1;
        @(negedge clk);
        check("R4 pending still blocks", grant_valid, 0);
        @(posedge clk); #1;
        pend_b = '0;
        run_b  = '0;
        repeat (2) run_cycle(HOLD);

        // R5: all slots at once enter in index order; R2 boundary 4 admitted
        run_b = '1;
        for (int i = 0; i < N; i++) occ_b[i] = OW'(LIM);
        occ_b[5] = OW'(LIM + 1);
        run_cycle(HOLD);
        run_b = '0;
        for (int k = 0; k < N; k++) run_cycle(HOLD);
        pend_b = '0;
        run_cycle(HOLD);

        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 400; c++) begin
                if (m == 3 && c == 200) rst = 1'b1;
                run_cycle(m);
                rst = 1'b0;
            end
        end
        // drain checks
        run_b = '0;
        repeat (N + 2) run_cycle(HOLD);
        check("R6 queue drained", grant_valid, 0);
        finish_run();
    end

endmodule